// File: doc/BRIEF.md
# Byte-Programmed Frequency Word Loader

This block sits between a narrow 8-bit processor bus and the phase-increment input of a numerically controlled oscillator. Software writes the 32-bit increment word one byte at a time into a staging buffer. The buffer has four byte lanes, and a 2-bit address picks the lane for each write. Each write happens on a falling edge of the active-low write strobe. Staged bytes have no effect downstream until a separate load strobe rises. The block then copies the whole staged word into the active increment register in one clock, so a partly written word never reaches the oscillator.

The block also drives an active-low sync pulse. The pulse marks the moment the new increment reaches the synthesized output after the oscillator's fixed pipeline latency. A similar pulse follows the release of reset. The sync output returns high as a clean rising edge, so it can drive the load strobe of a higher-order stage. This gives phase-continuous updates in a cascade of two oscillators.

Both strobes come from outside the clock domain. Each passes through a two-flop synchronizer, and its edges are detected on the synchronized copy.

Top module: `freq_word_loader`

## Requirements
- R1: The lane address `lane_sel` = {A1,A0} selects the byte lane as follows: 2'b11 selects word bits 7:0, 2'b01 selects bits 15:8, 2'b10 selects bits 23:16, and 2'b00 selects bits 31:24. Bit 0 of `bus_data` lands in the lowest bit of the selected lane. A write leaves the other three lanes unchanged.
- R2: A write happens only on a falling edge of `wr_n`. Data and lane are sampled at the third rising clock edge after `wr_n` falls. Holding `wr_n` low, changing the bus later, or a rising `wr_n` causes no further write.
- R3: Byte writes change only the staging buffer. `incr_word` keeps its value until a load.
- R4: A rising edge of `ld_strobe` copies the whole staged word to `incr_word` at the third rising clock edge after the rise. That edge is the commit edge. Holding `ld_strobe` high gives one load only, and `incr_word` is stable between commits.
- R5: Reset clears neither the staging buffer nor `incr_word`. A load after reset commits the bytes staged before reset.
- R6: `sync_n` is high while idle. It is low for exactly one cycle, following the 34th rising edge after a commit edge.
- R7: `sync_n` is high while `rst_n` is low. It is low for exactly one cycle following the 35th rising edge after `rst_n` is released, when no load intervenes.
- R8: A load that arrives while a sync countdown is running restarts the countdown. The pending pulse is dropped, and one pulse follows 34 edges after the newer commit edge.
- R9: When a write and a load are detected in the same cycle, the commit takes the staged word as it was before that write. The written byte is kept in the buffer for the next load.
- R10: The return of `sync_n` to high acts as a valid load strobe for a second loader. With `sync_n` of one instance wired to `ld_strobe` of another, the second commits its staged word four edges after the first one's pulse cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with the clock |
| wr_n | input | 1 | Asynchronous active-low byte write strobe |
| lane_sel | input | 2 | Byte lane address {A1,A0} |
| bus_data | input | 8 | Byte written into the selected lane |
| ld_strobe | input | 1 | Asynchronous load strobe; a rise commits the staged word |
| incr_word | output | 32 | Active phase-increment word |
| sync_n | output | 1 | Active-low one-cycle marker that the new word has reached the output |

## Verification
A byte write and a load commit can land on the same clock edge. The most delicate case is a write whose lane update coincides with the copy into the active register. The bench provokes this by dropping `wr_n` and raising `ld_strobe` in the same half cycle. Both strobes pass through identical synchronizers, so their detections coincide. The bench then checks two things: the active word shows the staged word from before the write, and a second load brings out the new byte. A second overlap, a load arriving during a running countdown, is judged by counting sync pulses in a window and checking the cycle of the only one.

// File: rtl/freq_ld_pkg.sv
package freq_ld_pkg;

  localparam int DEF_BYTE_W    = 8;
  localparam int DEF_LANES     = 4;
  localparam int DEF_LOAD_LAT  = 34;
  localparam int DEF_RESET_LAT = 35;
  localparam int DEF_SYNC_FF   = 2;

  // bits needed to hold the larger of two countdown start values
  function automatic int count_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1,
  parameter bit RISE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic evt
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_in};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE}};
      prev_q  <= IDLE;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  generate
    if (RISE) begin : g_rise
      assign evt = chain_q[STAGES-1] & ~prev_q;
    end else begin : g_fall
      assign evt = ~chain_q[STAGES-1] & prev_q;
    end
  endgenerate

  // an edge event can never repeat on the following cycle
  p_single_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

endmodule

// File: rtl/lane_stager.sv
module lane_stager #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int AW    = $clog2(LANES),
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [AW-1:0]     lane_idx,
  input  logic [BYTE_W-1:0] din,
  input  logic              commit,
  output logic [WORD_W-1:0] word
);

  logic [BYTE_W-1:0] stage_q [LANES];
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] staged;
  logic [WORD_W-1:0] act_q;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb lane_we[i] = wr_evt && (lane_idx == AW'(i));

      always_ff @(posedge clk) begin
        if (lane_we[i]) stage_q[i] <= din;
      end

      assign staged[i*BYTE_W +: BYTE_W] = stage_q[i];

      // a write to another lane leaves this lane alone
      p_lane_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && lane_idx != AW'(i)) |=> $stable(stage_q[i]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (commit) act_q <= staged;
  end

  assign word = act_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(word));

  p_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> word == $past(staged));

endmodule

// File: rtl/sync_timer.sv
module sync_timer #(
  parameter int LOAD_LAT  = 34,
  parameter int RESET_LAT = 35,
  localparam int CW = freq_ld_pkg::count_width(LOAD_LAT, RESET_LAT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  output logic sync_n
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sync_q, sync_d;
  logic          expiring;

  always_comb begin
    expiring = (cnt_q == CW'(1));
    sync_d   = !(expiring && !load_evt);
    if (load_evt)
      cnt_d = CW'(LOAD_LAT);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(RESET_LAT);
      sync_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  assign sync_n = sync_q;

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> sync_n);

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> sync_n);

  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> sync_n);

endmodule

// File: rtl/freq_word_loader.sv
module freq_word_loader #(
  parameter int BYTE_W    = freq_ld_pkg::DEF_BYTE_W,
  parameter int LANES     = freq_ld_pkg::DEF_LANES,
  parameter int LOAD_LAT  = freq_ld_pkg::DEF_LOAD_LAT,
  parameter int RESET_LAT = freq_ld_pkg::DEF_RESET_LAT,
  parameter int SYNC_FF   = freq_ld_pkg::DEF_SYNC_FF,
  localparam int AW       = $clog2(LANES),
  localparam int WORD_W   = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     lane_sel,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic              ld_strobe,
  output logic [WORD_W-1:0] incr_word,
  output logic              sync_n
);

  logic          wr_evt;
  logic          ld_evt;
  logic [AW-1:0] lane_idx;

  // lane index is the bit-reversed complement of the bus address
  generate
    for (genvar b = 0; b < AW; b++) begin : g_dec
      assign lane_idx[b] = ~lane_sel[AW-1-b];
    end
  endgenerate

  strobe_sync #(.STAGES(SYNC_FF), .IDLE(1'b1), .RISE(1'b0)) u_wr_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wr_n),
    .evt      (wr_evt)
  );

  strobe_sync #(.STAGES(SYNC_FF), .IDLE(1'b1), .RISE(1'b1)) u_ld_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ld_strobe),
    .evt      (ld_evt)
  );

  lane_stager #(.BYTE_W(BYTE_W), .LANES(LANES)) u_stager (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_evt   (wr_evt),
    .lane_idx (lane_idx),
    .din      (bus_data),
    .commit   (ld_evt),
    .word     (incr_word)
  );

  sync_timer #(.LOAD_LAT(LOAD_LAT), .RESET_LAT(RESET_LAT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (ld_evt),
    .sync_n   (sync_n)
  );

  // a pulse and a commit never share a cycle boundary
  p_commit_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_evt |=> sync_n);

endmodule

// File: tb/freq_word_loader_tb_top.sv
module freq_word_loader_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_n, ld_strobe;
  logic [1:0]  lane_sel;
  logic [7:0]  bus_data;
  logic [31:0] incr_word;
  logic        sync_n;
  logic        u_wr_n;
  logic [1:0]  u_lane;
  logic [7:0]  u_data;
  logic [31:0] u_word;
  logic        u_sync_n;

  int checks = 0, fails = 0, cyc = 0;
  int last_low = -1, low_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  freq_word_loader dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .lane_sel(lane_sel),
    .bus_data(bus_data), .ld_strobe(ld_strobe),
    .incr_word(incr_word), .sync_n(sync_n));

  freq_word_loader hi_i (
    .clk(clk), .rst_n(rst_n), .wr_n(u_wr_n), .lane_sel(u_lane),
    .bus_data(u_data), .ld_strobe(sync_n),
    .incr_word(u_word), .sync_n(u_sync_n));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        wh[$], lh[$];
  int        m_cnt;
  bit        m_sync;
  bit [31:0] m_buf, m_act;
  bit [3:0]  m_known;
  bit        m_act_known = 0;

  function automatic int lane_of(input logic [1:0] a);
    case (a)
      2'b11:   return 0;
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      wh = '{1, 1, 1};
      lh = '{1, 1, 1};
      m_cnt = 35;
      m_sync = 1;
    end else begin
      bit wfall, lrise;
      wfall = (wh[1] == 0) && (wh[2] == 1);
      lrise = (lh[1] == 1) && (lh[2] == 0);
      m_sync = !(m_cnt == 1 && !lrise);
      m_cnt = lrise ? 34 : (m_cnt > 0 ? m_cnt - 1 : 0);
      if (lrise) begin
        m_act = m_buf;
        m_act_known = &m_known;
      end
      if (wfall) begin
        m_buf[8*lane_of(lane_sel) +: 8] = bus_data;
        m_known[lane_of(lane_sel)] = 1;
      end
      wh.push_front(wr_n); void'(wh.pop_back());
      lh.push_front(ld_strobe); void'(lh.pop_back());
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      if (rst_n) begin
        chk(sync_n === m_sync, "R6/R7 sync per-cycle", {31'd0, sync_n}, {31'd0, m_sync});
        if (m_act_known)
          chk(incr_word === m_act, "R4 word per-cycle", incr_word, m_act);
        if (sync_n == 0) begin
          last_low = cyc;
          low_cnt++;
        end
      end else begin
        chk(sync_n === 1'b1, "R7 high in reset", {31'd0, sync_n}, 32'd1);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_until(input int n);
    while (cyc < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic write_byte(input bit upper, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (upper) begin u_lane = a; u_data = d; u_wr_n = 0; end
    else begin lane_sel = a; bus_data = d; wr_n = 0; end
    repeat (4) @(negedge clk);
    if (upper) u_data = ~d; else bus_data = ~d;   // late bus change must be ignored
    repeat (2) @(negedge clk);
    if (upper) u_wr_n = 1; else wr_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ld_rise(output int e);
    @(negedge clk);
    ld_strobe = 1;
    e = cyc;
  endtask

  task automatic ld_fall();
    @(negedge clk);
    ld_strobe = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_and_wait(output int e);
    ld_rise(e);
    wait_until(e + 6);
    ld_fall();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired cyc=%0d actual=%h expected=%h", cyc, 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int e, e2, r, lc;
    logic [31:0] u_prev;
    rst_n = 0; wr_n = 1; ld_strobe = 0; lane_sel = 0; bus_data = 0;
    u_wr_n = 1; u_lane = 0; u_data = 0;
    repeat (3) @(posedge clk);
    #1 chk(sync_n === 1'b1, "R7 reset state", {31'd0, sync_n}, 32'd1);
    @(negedge clk); rst_n = 1; r = cyc;
    lc = low_cnt;
    wait_until(r + 37);
    chk(last_low == r + 35, "R7 reset pulse cycle", last_low, r + 35);
    chk(low_cnt - lc == 1, "R7 single reset pulse", low_cnt - lc, 1);

    // R1 full word in scrambled lane order
    write_byte(0, 2'b10, 8'hC3);
    write_byte(0, 2'b11, 8'h74);
    write_byte(0, 2'b00, 8'hA5);
    write_byte(0, 2'b01, 8'h1E);
    lc = low_cnt;
    ld_rise(e);
    wait_until(e + 3);
    chk(incr_word === 32'hA5C31E74, "R1/R4 commit at third edge", incr_word, 32'hA5C31E74);
    wait_until(e + 6);
    ld_fall();
    chk(incr_word === 32'hA5C31E74, "R4 held strobe loads once", incr_word, 32'hA5C31E74);
    wait_until(e + 40);
    chk(last_low == e + 37, "R6 pulse 34 edges after commit", last_low, e + 37);
    chk(low_cnt - lc == 1, "R6 one-cycle pulse", low_cnt - lc, 1);

    // R2/R3 single lane overwrite, invisible until load
    write_byte(0, 2'b01, 8'h5A);
    chk(incr_word === 32'hA5C31E74, "R3 staging not visible", incr_word, 32'hA5C31E74);
    load_and_wait(e);
    chk(incr_word === 32'hA5C35A74, "R2 first byte kept, R1 lane 15:8", incr_word, 32'hA5C35A74);

    // R8 restart
    wait_until(e + 45);
    lc = low_cnt;
    load_and_wait(e);
    wait_until(e + 20);
    load_and_wait(e2);
    wait_until(e2 + 42);
    chk(low_cnt - lc == 1, "R8 pending pulse dropped", low_cnt - lc, 1);
    chk(last_low == e2 + 37, "R8 pulse follows newer load", last_low, e2 + 37);

    // R9 write and load detected together
    @(negedge clk);
    lane_sel = 2'b11; bus_data = 8'hEE; wr_n = 0; ld_strobe = 1; e = cyc;
    wait_until(e + 4);
    chk(incr_word === 32'hA5C35A74, "R9 commit takes pre-write word", incr_word, 32'hA5C35A74);
    @(negedge clk); wr_n = 1; ld_strobe = 0;
    repeat (3) @(negedge clk);
    load_and_wait(e);
    chk(incr_word === 32'hA5C35AEE, "R9 written byte kept", incr_word, 32'hA5C35AEE);

    // R5 reset keeps buffer and active word
    write_byte(0, 2'b00, 8'h3C);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    #1 chk(incr_word === 32'hA5C35AEE, "R5 active kept over reset", incr_word, 32'hA5C35AEE);
    load_and_wait(e);
    chk(incr_word === 32'h3CC35AEE, "R5 buffer kept over reset", incr_word, 32'h3CC35AEE);

    // R10 cascade
    wait_until(e + 45);
    write_byte(1, 2'b11, 8'h3C);
    write_byte(1, 2'b01, 8'h2D);
    write_byte(1, 2'b10, 8'h1E);
    write_byte(1, 2'b00, 8'h0F);
    u_prev = u_word;
    ld_rise(e);
    wait_until(e + 40);
    chk(u_word === u_prev, "R10 upper not yet loaded", u_word, u_prev);
    wait_until(e + 41);
    chk(u_word === 32'h0F1E2D3C, "R10 upper loads after pulse", u_word, 32'h0F1E2D3C);
    ld_fall();
    wait_until(cyc + 5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule